// File: doc/BRIEF.md
# ADSR Envelope Generator with Exponential Decay

This block produces an 8-bit amplitude envelope for one synthesizer voice. Each enabled clock cycle is one envelope tick. A 15-bit prescaler divides the tick down to a rate chosen by a 4-bit code. A second divider stretches the steps during decay and release. Together they give a piecewise-linear approximation of an exponential fall.

Software sets up the block through a narrow write port that holds three registers:
- **select 0**, control: bit 0 is the gate.
- **select 1**, rise/fall: attack code in bits 7:4, decay code in bits 3:0.
- **select 2**, hold/release: sustain code in bits 7:4, release code in bits 3:0.

Raising the gate starts the attack, which then flows into decay and holds at the sustain level. Lowering the gate starts the release. The envelope value is always visible on `env_out`.

Several hardware quirks are reproduced on purpose:
- The prescaler is never cleared by a gate edge.
- A period that is written below the current prescaler count makes the prescaler run all the way round before the next step.
- The envelope latches at zero once it lands there.
- The envelope may wrap modulo 256 in both directions.

Top module: `env_adsr`

## Requirements
- R1: After reset, `env_out` is 0x00, the block is in release with the zero latch set, and the envelope stays at 0x00 while ticks run and the gate stays low.
- R2: With a period P selected, an envelope step opportunity occurs every P enabled cycles, and the prescaler counts from 0 after each opportunity.
- R3: Rate codes 0 to 15 select the periods 9, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954, 3126, 3907, 11720, 19532 and 31251 cycles. Select 1 carries attack in bits 7:4 and decay in bits 3:0. Select 2 carries sustain in bits 7:4 and release in bits 3:0. Select 0 bit 0 is the gate.
- R4: In attack, every opportunity adds one to the envelope. When the envelope reaches 0xFF, the state becomes decay and the decay period is used from then on.
- R5: In decay, the envelope falls by one per step until it equals the sustain code copied into both nibbles (code s gives 0x11*s). It then holds there.
- R6: In decay and release, a step needs 1, 2, 4, 8, 16 or 30 opportunities. The divisor is reloaded when the envelope lands exactly on 0xFF, 0x5D, 0x36, 0x1A, 0x0E or 0x06 respectively. Landing on 0x00 reloads it to 1.
- R7: Landing on 0x00 sets a zero latch. While the latch is set the envelope does not change. Only a rising gate edge clears the latch.
- R8: In release, the envelope falls by one per step modulo 256, so 0x00 becomes 0xFF when the latch is clear.
- R9: If the active period is changed to a value below the current prescaler count, the next opportunity comes 32767+P enabled cycles after the previous one.
- R10: Writing select 1 changes the active period at once in attack or decay, and has no effect on it in release. Writing select 2 changes the active period only in release.
- R11: While `step_en` is low, the prescaler, dividers and envelope hold their values. Register writes are still accepted during this time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Envelope tick enable, one tick per enabled cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 attack/decay, 2 sustain/release |
| wr_data | input | 8 | Register write data |
| env_out | output | 8 | Current envelope value |

## Verification
The assertions check the following on every cycle:
- In attack, the envelope only moves up by one.
- In release, the envelope only moves down by one.
- The envelope stays still at the sustain floor.
- The envelope stays still under the zero latch.
- The envelope stays still while ticks are disabled.
- The latch never coexists with a non-zero envelope.
- The exponential sub-counter stays below its divisor.

The bench scenarios are what show the timing. They measure the exact spacing of steps for every rate code and for every exponential segment of a full release. They also show the 32767+P cycle delay after a late period write, and that each register write affects the period only in the states where it should. Finally, they show that the envelope wraps from zero to 0xFF after a short gate pulse.

// File: rtl/env_adsr.sv
module env_adsr #(
  parameter int PRE_W = 15,
  parameter int EXP_W = 5,
  parameter int ENV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  output logic [ENV_W-1:0] env_out
);

  typedef enum logic [1:0] {ST_ATK = 2'd0, ST_DEC = 2'd1, ST_REL = 2'd2} st_t;

  localparam logic [ENV_W-1:0] ENV_TOP = {ENV_W{1'b1}};

  st_t              st_q;
  logic             gate_q, frz_q;
  logic [3:0]       atk_q, dec_q, sus_q, rel_q;
  logic [PRE_W-1:0] pre_q;
  logic [EXP_W-1:0] exp_cnt_q, exp_per_q;
  logic [ENV_W-1:0] env_q;

  function automatic logic [PRE_W-1:0] rate_lut(input logic [3:0] c);
    case (c)
      4'd0:    rate_lut = PRE_W'(9);
      4'd1:    rate_lut = PRE_W'(32);
      4'd2:    rate_lut = PRE_W'(63);
      4'd3:    rate_lut = PRE_W'(95);
      4'd4:    rate_lut = PRE_W'(149);
      4'd5:    rate_lut = PRE_W'(220);
      4'd6:    rate_lut = PRE_W'(267);
      4'd7:    rate_lut = PRE_W'(313);
      4'd8:    rate_lut = PRE_W'(392);
      4'd9:    rate_lut = PRE_W'(977);
      4'd10:   rate_lut = PRE_W'(1954);
      4'd11:   rate_lut = PRE_W'(3126);
      4'd12:   rate_lut = PRE_W'(3907);
      4'd13:   rate_lut = PRE_W'(11720);
      4'd14:   rate_lut = PRE_W'(19532);
      default: rate_lut = PRE_W'(31251);
    endcase
  endfunction

  logic [3:0]       code;
  logic [PRE_W-1:0] period;
  logic [PRE_W:0]   pre_inc;
  logic [PRE_W-1:0] pre_nx;
  logic             hit, exp_hit, advance;
  logic [ENV_W-1:0] sus_lvl, env_nx;
  logic             wr_ctl, gate_rise, gate_fall;

  assign code      = (st_q == ST_ATK) ? atk_q : (st_q == ST_DEC) ? dec_q : rel_q;
  assign period    = rate_lut(code);
  assign pre_inc   = {1'b0, pre_q} + 1'b1;
  assign pre_nx    = pre_inc[PRE_W] ? pre_inc[PRE_W-1:0] + 1'b1 : pre_inc[PRE_W-1:0];
  assign hit       = step_en && (pre_nx == period);
  assign exp_hit   = (st_q == ST_ATK) || (exp_cnt_q + EXP_W'(1) == exp_per_q);
  assign advance   = hit && exp_hit && !frz_q;
  assign sus_lvl   = ENV_W'({sus_q, sus_q});
  assign wr_ctl    = wr_en && (wr_sel == 2'd0);
  assign gate_rise = wr_ctl && wr_data[0] && !gate_q;
  assign gate_fall = wr_ctl && !wr_data[0] && gate_q;
  assign env_out   = env_q;

  always_comb begin
    case (st_q)
      ST_ATK:  env_nx = env_q + 1'b1;
      ST_DEC:  env_nx = (env_q == sus_lvl) ? env_q : env_q - 1'b1;
      default: env_nx = env_q - 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_REL;
      gate_q    <= 1'b0;
      frz_q     <= 1'b1;
      atk_q     <= '0;
      dec_q     <= '0;
      sus_q     <= '0;
      rel_q     <= '0;
      pre_q     <= '0;
      exp_cnt_q <= '0;
      exp_per_q <= EXP_W'(1);
      env_q     <= '0;
    end else begin
      if (step_en) pre_q <= hit ? '0 : pre_nx;
      if (hit) exp_cnt_q <= exp_hit ? '0 : exp_cnt_q + 1'b1;
      if (advance) begin
        env_q <= env_nx;
        if (st_q == ST_ATK && env_nx == ENV_TOP) st_q <= ST_DEC;
        case (env_nx)
          8'hFF: exp_per_q <= EXP_W'(1);
          8'h5D: exp_per_q <= EXP_W'(2);
          8'h36: exp_per_q <= EXP_W'(4);
          8'h1A: exp_per_q <= EXP_W'(8);
          8'h0E: exp_per_q <= EXP_W'(16);
          8'h06: exp_per_q <= EXP_W'(30);
          8'h00: begin
            exp_per_q <= EXP_W'(1);
            frz_q     <= 1'b1;
          end
          default: ;
        endcase
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin
            gate_q <= wr_data[0];
            if (gate_rise) begin
              st_q  <= ST_ATK;
              frz_q <= 1'b0;
            end else if (gate_fall) begin
              st_q <= ST_REL;
            end
          end
          2'd1: begin
            atk_q <= wr_data[7:4];
            dec_q <= wr_data[3:0];
          end
          2'd2: begin
            sus_q <= wr_data[7:4];
            rel_q <= wr_data[3:0];
          end
          default: ;
        endcase
      end
    end
  end

  assert_attack_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ATK) |=> (env_q == $past(env_q)) || (env_q == $past(env_q) + 1'b1));

  assert_release_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REL) |=> (env_q == $past(env_q)) || (env_q == $past(env_q) - 1'b1));

  assert_sustain_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEC && env_q == sus_lvl) |=> $stable(env_q));

  assert_freeze_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q |=> $stable(env_q));

  assert_freeze_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q |-> (env_q == '0));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(env_q) && $stable(pre_q) && $stable(exp_cnt_q));

  assert_exp_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exp_cnt_q < exp_per_q);

endmodule

// File: tb/env_adsr_tb.sv
module env_adsr_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] env_out;

  int vecs = 0;
  int miss = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  env_adsr u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .env_out(env_out)
  );

  function automatic int rate_exp(input int k);
    case (k)
      0: return 9;      1: return 32;     2: return 63;     3: return 95;
      4: return 149;    5: return 220;    6: return 267;    7: return 313;
      8: return 392;    9: return 977;    10: return 1954;  11: return 3126;
      12: return 3907;  13: return 11720; 14: return 19532; default: return 31251;
    endcase
  endfunction

  function automatic int exp_mult(input int v);
    if (v >= 8'h5E) return 1;
    if (v >= 8'h37) return 2;
    if (v >= 8'h1B) return 4;
    if (v >= 8'h0F) return 8;
    if (v >= 8'h07) return 16;
    return 30;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_chg(output int n);
    logic [7:0] prev;
    prev = env_out;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (env_out == prev && n < 40000);
  endtask

  task automatic meas_wr(input logic [1:0] s, input logic [7:0] d, output int n);
    int n2;
    wr(s, d);
    wait_chg(n2);
    n = n2 + 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vecs++; miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    int n, v, tot;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset env", env_out, 0);
    repeat (200) @(negedge clk);
    chk("R1 idle after reset", env_out, 0);

    wr(2'd1, 8'h00);
    wr(2'd2, 8'h80);
    wr(2'd0, 8'h01);
    wait_chg(n);
    chk("R4 first attack step", env_out, 1);
    while (env_out != 8'hFF) begin
      v = env_out;
      wait_chg(n);
      chk("R2 attack interval", n, 9);
      chk("R4 attack increment", env_out, v + 1);
    end
    wait_chg(n);
    chk("R4 decay period after top", n, 9);
    chk("R4 decay begins", env_out, 8'hFE);
    while (env_out != 8'hC0) begin
      v = env_out;
      wait_chg(n);
      chk("R5 decay interval", n, 9);
      chk("R5 decay decrement", env_out, v - 1);
    end
    meas_wr(2'd2, 8'h8F, n);
    chk("R10 release write ignored in decay", n, 9);
    meas_wr(2'd1, 8'h01, n);
    chk("R10 decay write applies at once", n, 32);
    meas_wr(2'd2, 8'h80, n);
    chk("R10 release write ignored in decay", n, 32);
    while (env_out != 8'h88) begin
      v = env_out;
      wait_chg(n);
      chk("R5 decay interval", n, 32);
      chk("R5 decay decrement", env_out, v - 1);
    end
    repeat (300) @(negedge clk);
    chk("R5 sustain hold", env_out, 8'h88);

    wr(2'd2, 8'h81);
    wr(2'd0, 8'h00);
    wait_chg(n);
    chk("R8 release first step", env_out, 8'h87);
    meas_wr(2'd2, 8'h80, n);
    chk("R10 release write applies in release", n, 9);
    chk("R8 release decrement", env_out, 8'h86);
    while (env_out != 8'h00) begin
      v = env_out;
      if (v == 8'h80) meas_wr(2'd1, 8'hF1, n);
      else wait_chg(n);
      chk((v == 8'h80) ? "R10 attack/decay write ignored in release" : "R6 exponential interval",
          n, 9 * exp_mult(v));
      chk("R8 release decrement", env_out, v - 1);
    end
    repeat (2000) @(negedge clk);
    chk("R7 zero latch holds", env_out, 0);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h80);
    repeat (100) @(negedge clk);
    chk("R7 latch kept without rising gate", env_out, 0);

    wr(2'd1, 8'h00);
    step_en = 1'b0;
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h00);
    chk("R11 no step while disabled", env_out, 0);
    step_en = 1'b1;
    wait_chg(n);
    chk("R8 wrap from zero", env_out, 8'hFF);
    wait_chg(n);
    chk("R6 divisor one at top", n, 9);
    chk("R8 continues falling", env_out, 8'hFE);
    while (env_out != 8'hD0) wait_chg(n);

    wr(2'd0, 8'h01);
    wait_chg(n);
    chk("R4 attack resumes", env_out, 8'hD1);
    for (int k = 0; k < 16; k++) begin
      v = env_out;
      meas_wr(2'd1, 8'((k << 4)), n);
      chk("R3 rate code period", n, rate_exp(k));
      chk("R4 attack increment", env_out, v + 1);
    end

    meas_wr(2'd1, 8'h30, n);
    chk("R3 rate code 3", n, 95);
    v = env_out;
    tot = 0;
    repeat (50) begin
      @(negedge clk);
      tot++;
    end
    chk("R9 no step before late write", env_out, v);
    wr(2'd1, 8'h00);
    tot++;
    wait_chg(n);
    chk("R9 late write wraps prescaler", tot + n, 32767 + 9);
    wait_chg(n);
    chk("R9 normal interval after wrap", n, 9);

    v = env_out;
    repeat (3) @(negedge clk);
    step_en = 1'b0;
    repeat (100) @(negedge clk);
    chk("R11 envelope held while disabled", env_out, v);
    step_en = 1'b1;
    wait_chg(n);
    chk("R11 prescaler resumes count", 3 + n, 9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule